// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block attaches three 8-bit parallel ports to a simple host bus. The host reaches it through an active-low chip select, active-low read and write strobes, a two-bit register address and an 8-bit data path. Writes to the control address either redefine the port configuration or change a single port C line. The configuration covers the direction of ports A and B, the direction of each half of port C, and whether group A (port A) and group B (port B) run as plain I/O or as strobed handshake ports.

In handshake mode a port borrows three port C lines: a strobe or acknowledge input, a buffer-full output and an interrupt request output. Input ports capture data on the falling edge of the strobe. Output ports tell the peripheral when new data is waiting. Every port line is presented as an input value, an output value and an output enable, so the surrounding pad logic can build the tristate drivers.

Bus strobes are sampled on the rising edge of `clk`. A write takes effect on the edge where chip select and write are both low. Read data appears on `dout` combinationally while chip select and read are low. Any clearing side effect of a read happens on the clock edge at the end of that read cycle.

Top module: `ppi_core`

## Requirements
- R1: After reset every output enable (`pa_oe`, `pb_oe`, `pc_oe`) is zero and every output latch is zero. Both groups are in plain mode, and a read of the control address (11) returns 0x00.
- R2: With `cs_n` high, a low `wr_n` changes no state and `dout` is 0x00. `dout` is also 0x00 whenever `rd_n` is high.
- R3: Address 00 reaches port A, 01 reaches port B, 10 reaches port C and 11 reaches the control register.
- R4: A control write with bit 7 = 1 is a mode word, and its direction bits use 1 = input. Bit 4 sets the port A direction, bit 3 the port C bits 7:4, bit 1 port B and bit 0 port C bits 3:0. An output port drives its latch on its pins with output enable all ones and holds that value until the next write. Reading an output port returns its latch.
- R5: In plain mode, reading an input port returns the live pin value at the time of the read. Nothing is latched.
- R6: The two halves of port C follow their own direction bits. Reading port C returns pin values for input bits and latch values for output bits.
- R7: A control write with bit 7 = 0 sets port C latch bit number din[3:1] to din[0] and leaves the other bits unchanged.
- R8: Every mode word clears the port A, B and C latches, the interrupt enables, the buffer-full flags and the interrupt requests.
- R9: Group A is strobed when mode bits 6:5 = 01, and group B is strobed when mode bit 2 = 1. Port C lines are then reserved as follows:
  - Port A as input: line 3 is the request, line 4 is the active-low strobe input and line 5 is buffer-full (high = full).
  - Port A as output: line 3 is the request, line 6 is the active-low acknowledge input and line 7 is buffer-full (low = full).
  - Port B: line 0 is the request, line 2 is the strobe or acknowledge input and line 1 is buffer-full (high = full for input, low = full for output).
  - The interrupt enable is the port C latch bit at the strobe or acknowledge position. A port C read returns the enable at that position and the pin value on the request and buffer-full lines.
- R10: Strobed input: a falling strobe captures the port pins and sets buffer-full. A rising strobe sets the request. A host read of the port returns the captured byte and clears both buffer-full and the request.
- R11: Strobed output: a host write loads the latch, sets buffer-full and clears the request. A falling acknowledge clears buffer-full, and a rising acknowledge sets the request.
- R12: A request line is high only while both its request flag and its interrupt enable are set. Clearing the enable drops the line, and setting it again restores the line.
- R13: In strobed mode, writes to port C or single-bit writes that target a reserved request or buffer-full line do not change that line. Port C data writes leave reserved latch bits, including the enables, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; bus strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Register address |
| din | input | 8 | Write data from the host |
| dout | output | 8 | Read data to the host |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A drive values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B drive values |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin values, including strobe and acknowledge inputs |
| pc_out | output | 8 | Port C drive values |
| pc_oe | output | 8 | Port C output enables |

## Verification
The assertions assume that the strobe and acknowledge inputs on port C are synchronous to `clk` and are stable at each rising edge. They also assume that bus accesses drive `cs_n` low together with exactly one strobe. The stimulus changes pins and bus signals only on falling clock edges, and it holds every bus access for exactly one cycle. Each handshake line is kept idle high before any mode word that reserves it, so entering strobed mode never produces a spurious edge.

// File: rtl/ppi_pkg.sv
`timescale 1ns/1ps
package ppi_pkg;
  localparam int PORT_W = 8;
  localparam int HALF_W = PORT_W / 2;
  localparam int SEL_W  = $clog2(PORT_W);

  typedef struct packed {
    logic a_hs;   // group A strobed
    logic a_in;   // port A input
    logic ch_in;  // port C upper half input
    logic b_hs;   // group B strobed
    logic b_in;   // port B input
    logic cl_in;  // port C lower half input
  } ppi_mode_t;

  localparam ppi_mode_t MODE_RST = '{a_hs: 1'b0, a_in: 1'b1, ch_in: 1'b1,
                                     b_hs: 1'b0, b_in: 1'b1, cl_in: 1'b1};

  function automatic ppi_mode_t decode_mode(input logic [PORT_W-1:0] w);
    ppi_mode_t m;
    m.a_hs  = (w[6:5] == 2'b01);
    m.a_in  = w[4];
    m.ch_in = w[3];
    m.b_hs  = w[2];
    m.b_in  = w[1];
    m.cl_in = w[0];
    return m;
  endfunction

  // port C line carrying the request of a port
  function automatic logic [SEL_W-1:0] irq_line(input logic port_b);
    return port_b ? SEL_W'(0) : SEL_W'(3);
  endfunction

  // port C line carrying the strobe / acknowledge input (also the enable bit)
  function automatic logic [SEL_W-1:0] sync_line(input logic port_b, input logic dir_in);
    if (port_b) return SEL_W'(2);
    return dir_in ? SEL_W'(4) : SEL_W'(6);
  endfunction

  // port C line carrying the buffer-full indication
  function automatic logic [SEL_W-1:0] full_line(input logic port_b, input logic dir_in);
    if (port_b) return SEL_W'(1);
    return dir_in ? SEL_W'(5) : SEL_W'(7);
  endfunction

  // port C latch bits that belong to handshake logic under a mode
  function automatic logic [PORT_W-1:0] hs_mask(input ppi_mode_t m);
    logic [PORT_W-1:0] k;
    k = '0;
    if (m.a_hs) begin
      k[irq_line(1'b0)]          = 1'b1;
      k[sync_line(1'b0, m.a_in)] = 1'b1;
      k[full_line(1'b0, m.a_in)] = 1'b1;
    end
    if (m.b_hs) begin
      k[irq_line(1'b1)]          = 1'b1;
      k[sync_line(1'b1, m.b_in)] = 1'b1;
      k[full_line(1'b1, m.b_in)] = 1'b1;
    end
    return k;
  endfunction
endpackage

// File: rtl/ppi_ctrl.sv
`timescale 1ns/1ps
module ppi_ctrl
  import ppi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [PORT_W-1:0] din,
  output ppi_mode_t         mode,
  output logic [PORT_W-1:0] pc_latch,
  output logic              mode_load,
  output logic [1:0]        port_wr,
  output logic [1:0]        port_rd,
  output logic              bus_rd
);
  localparam logic [1:0] ADR_A = 2'b00;
  localparam logic [1:0] ADR_B = 2'b01;
  localparam logic [1:0] ADR_C = 2'b10;
  localparam logic [1:0] ADR_K = 2'b11;

  logic wr_act, ctl_wr, bit_op, pc_wr;
  logic [PORT_W-1:0] keep;

  assign wr_act     = !cs_n && !wr_n;
  assign bus_rd     = !cs_n && !rd_n && wr_n;
  assign ctl_wr     = wr_act && (addr == ADR_K);
  assign mode_load  = ctl_wr && din[PORT_W-1];
  assign bit_op     = ctl_wr && !din[PORT_W-1];
  assign pc_wr      = wr_act && (addr == ADR_C);
  assign port_wr[0] = wr_act && (addr == ADR_A);
  assign port_wr[1] = wr_act && (addr == ADR_B);
  assign port_rd[0] = bus_rd && (addr == ADR_A);
  assign port_rd[1] = bus_rd && (addr == ADR_B);
  assign keep       = hs_mask(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= MODE_RST;
      pc_latch <= '0;
    end else if (mode_load) begin
      mode     <= decode_mode(din);
      pc_latch <= '0;
    end else if (bit_op) begin
      pc_latch[din[SEL_W:1]] <= din[0];
    end else if (pc_wr) begin
      pc_latch <= (pc_latch & keep) | (din & ~keep);
    end
  end
endmodule

// File: rtl/ppi_hs_port.sv
`timescale 1ns/1ps
module ppi_hs_port #(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_en,
  input  logic              dir_in,
  input  logic              mode_load,
  input  logic              wr_evt,
  input  logic              rd_evt,
  input  logic [PORT_W-1:0] din,
  input  logic [PORT_W-1:0] pin_in,
  input  logic              sync_pin,
  input  logic              irq_en,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe,
  output logic [PORT_W-1:0] rd_val,
  output logic              full,
  output logic              irq,
  output logic              sync_fall,
  output logic              sync_rise
);
  logic sync_q;
  logic req;
  logic [PORT_W-1:0] out_latch;
  logic [PORT_W-1:0] in_latch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 1'b1;
    else        sync_q <= sync_pin;
  end

  assign sync_fall = hs_en && sync_q && !sync_pin;
  assign sync_rise = hs_en && !sync_q && sync_pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_latch <= '0;
      in_latch  <= '0;
    end else if (mode_load) begin
      out_latch <= '0;
      in_latch  <= '0;
    end else begin
      if (wr_evt && !dir_in) out_latch <= din;
      if (sync_fall && dir_in) in_latch <= pin_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      req  <= 1'b0;
    end else if (mode_load) begin
      full <= 1'b0;
      req  <= 1'b0;
    end else if (hs_en) begin
      if (dir_in) begin
        if (sync_fall)   full <= 1'b1;
        else if (rd_evt) full <= 1'b0;
        if (sync_rise)   req  <= 1'b1;
        else if (rd_evt) req  <= 1'b0;
      end else begin
        if (wr_evt)         full <= 1'b1;
        else if (sync_fall) full <= 1'b0;
        if (wr_evt)         req  <= 1'b0;
        else if (sync_rise) req  <= 1'b1;
      end
    end
  end

  assign irq     = req && irq_en;
  assign pin_out = out_latch;
  assign pin_oe  = dir_in ? '0 : '1;
  assign rd_val  = dir_in ? (hs_en ? in_latch : pin_in) : out_latch;
endmodule

// File: rtl/ppi_pc_mux.sv
`timescale 1ns/1ps
module ppi_pc_mux
  import ppi_pkg::*;
(
  input  ppi_mode_t         mode,
  input  logic [1:0]        hs_on,
  input  logic [1:0]        hs_dir,
  input  logic [PORT_W-1:0] pc_latch,
  input  logic [PORT_W-1:0] pc_in,
  input  logic [1:0]        full,
  input  logic [1:0]        irq,
  output logic [PORT_W-1:0] pc_out,
  output logic [PORT_W-1:0] pc_oe,
  output logic [PORT_W-1:0] pc_rd,
  output logic [1:0]        sync_pin,
  output logic [1:0]        irq_en
);
  logic [1:0] full_pin;

  assign full_pin[0] = hs_dir[0] ? full[0] : !full[0];
  assign full_pin[1] = hs_dir[1] ? full[1] : !full[1];

  always_comb begin
    for (int i = 0; i < PORT_W; i++) begin
      if (((i >= HALF_W) ? mode.ch_in : mode.cl_in)) begin
        pc_oe[i] = 1'b0;
        pc_rd[i] = pc_in[i];
      end else begin
        pc_oe[i] = 1'b1;
        pc_rd[i] = pc_latch[i];
      end
      pc_out[i] = pc_latch[i];
    end
    for (int p = 0; p < 2; p++) begin
      sync_pin[p] = pc_in[sync_line(p == 1, hs_dir[p])];
      irq_en[p]   = pc_latch[sync_line(p == 1, hs_dir[p])];
      if (hs_on[p]) begin
        pc_out[irq_line(p == 1)] = irq[p];
        pc_oe[irq_line(p == 1)]  = 1'b1;
        pc_rd[irq_line(p == 1)]  = irq[p];
        pc_out[full_line(p == 1, hs_dir[p])] = full_pin[p];
        pc_oe[full_line(p == 1, hs_dir[p])]  = 1'b1;
        pc_rd[full_line(p == 1, hs_dir[p])]  = full_pin[p];
        pc_out[sync_line(p == 1, hs_dir[p])] = 1'b0;
        pc_oe[sync_line(p == 1, hs_dir[p])]  = 1'b0;
        pc_rd[sync_line(p == 1, hs_dir[p])]  = pc_latch[sync_line(p == 1, hs_dir[p])];
      end
    end
  end
endmodule

// File: rtl/ppi_core.sv
`timescale 1ns/1ps
module ppi_core
  import ppi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [PORT_W-1:0] din,
  output logic [PORT_W-1:0] dout,
  input  logic [PORT_W-1:0] pa_in,
  output logic [PORT_W-1:0] pa_out,
  output logic [PORT_W-1:0] pa_oe,
  input  logic [PORT_W-1:0] pb_in,
  output logic [PORT_W-1:0] pb_out,
  output logic [PORT_W-1:0] pb_oe,
  input  logic [PORT_W-1:0] pc_in,
  output logic [PORT_W-1:0] pc_out,
  output logic [PORT_W-1:0] pc_oe
);
  ppi_mode_t         mode;
  logic [PORT_W-1:0] pc_latch;
  logic [PORT_W-1:0] pc_rd;
  logic              mode_load;
  logic              bus_rd;
  logic [1:0]        port_wr, port_rd;
  logic [1:0]        hs_on, hs_dir;
  logic [1:0]        full, irq, irq_en, sync_pin;
  logic [1:0]        sync_fall, sync_rise;
  logic [PORT_W-1:0] p_in  [2];
  logic [PORT_W-1:0] p_out [2];
  logic [PORT_W-1:0] p_oe  [2];
  logic [PORT_W-1:0] p_rd  [2];

  assign hs_on[0]  = mode.a_hs;
  assign hs_on[1]  = mode.b_hs;
  assign hs_dir[0] = mode.a_in;
  assign hs_dir[1] = mode.b_in;
  assign p_in[0]   = pa_in;
  assign p_in[1]   = pb_in;

  ppi_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .mode(mode), .pc_latch(pc_latch),
    .mode_load(mode_load), .port_wr(port_wr), .port_rd(port_rd), .bus_rd(bus_rd)
  );

  for (genvar g = 0; g < 2; g++) begin : g_port
    ppi_hs_port #(.PORT_W(PORT_W)) u_port (
      .clk(clk), .rst_n(rst_n), .hs_en(hs_on[g]), .dir_in(hs_dir[g]),
      .mode_load(mode_load), .wr_evt(port_wr[g]), .rd_evt(port_rd[g]),
      .din(din), .pin_in(p_in[g]), .sync_pin(sync_pin[g]), .irq_en(irq_en[g]),
      .pin_out(p_out[g]), .pin_oe(p_oe[g]), .rd_val(p_rd[g]),
      .full(full[g]), .irq(irq[g]), .sync_fall(sync_fall[g]), .sync_rise(sync_rise[g])
    );
  end

  ppi_pc_mux u_pcmux (
    .mode(mode), .hs_on(hs_on), .hs_dir(hs_dir), .pc_latch(pc_latch),
    .pc_in(pc_in), .full(full), .irq(irq), .pc_out(pc_out), .pc_oe(pc_oe),
    .pc_rd(pc_rd), .sync_pin(sync_pin), .irq_en(irq_en)
  );

  assign pa_out = p_out[0];
  assign pa_oe  = p_oe[0];
  assign pb_out = p_out[1];
  assign pb_oe  = p_oe[1];

  always_comb begin
    dout = '0;
    if (bus_rd) begin
      case (addr)
        2'b00:   dout = p_rd[0];
        2'b01:   dout = p_rd[1];
        2'b10:   dout = pc_rd;
        default: dout = '0;
      endcase
    end
  end
endmodule

// File: rtl/ppi_chk.sv
`timescale 1ns/1ps
module ppi_chk #(
  parameter int PORT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              rd_n,
  input logic [PORT_W-1:0] dout,
  input logic [PORT_W-1:0] pa_out,
  input logic [PORT_W-1:0] pb_out,
  input logic [PORT_W-1:0] pc_out,
  input logic [PORT_W-1:0] pc_oe,
  input logic              mode_load,
  input logic [1:0]        hs_on,
  input logic [1:0]        hs_dir,
  input logic [1:0]        full,
  input logic [1:0]        irq_en,
  input logic [1:0]        sync_fall
);
  // R2
  cs_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(pa_out) && $stable(pb_out)));

  // R2
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> (dout == '0));

  // R8
  mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_load |=> (pa_out == '0 && pb_out == '0 && full == 2'b00));

  // R10
  in_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_on[0] && hs_dir[0] && sync_fall[0] && !mode_load) |=> full[0]);

  // R12
  irq_a_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_on[0] |-> (!pc_out[3] || irq_en[0]));

  // R12
  irq_b_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_on[1] |-> (!pc_out[0] || irq_en[1]));

  // R9
  sync_b_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_on[1] |-> !pc_oe[2]);
endmodule

bind ppi_core ppi_chk #(.PORT_W(ppi_pkg::PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .dout(dout),
  .pa_out(pa_out), .pb_out(pb_out), .pc_out(pc_out), .pc_oe(pc_oe),
  .mode_load(mode_load), .hs_on(hs_on), .hs_dir(hs_dir), .full(full),
  .irq_en(irq_en), .sync_fall(sync_fall)
);

// File: tb/tb_ppi_core.sv
`timescale 1ns/1ps
module tb_ppi_core;
  logic       clk = 1'b0;
  logic       rst_n, cs_n, rd_n, wr_n;
  logic [1:0] addr;
  logic [7:0] din, dout;
  logic [7:0] pa_in, pa_out, pa_oe, pb_in, pb_out, pb_oe, pc_in, pc_out, pc_oe;
  int vectors = 0;
  int miscompares = 0;
  logic [7:0] rv;

  // bench model for plain mode
  logic [7:0] la, lb, lc;
  logic am_in, bm_in, ch_in, cl_in;

  always #2.5 clk = ~clk;

  ppi_core dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = a; din = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    #1 d = dout;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  function automatic logic [7:0] exp_pc_rd(input logic [7:0] lat, input logic [7:0] pins,
                                           input logic hi_in, input logic lo_in);
    logic [7:0] r;
    r[7:4] = hi_in ? pins[7:4] : lat[7:4];
    r[3:0] = lo_in ? pins[3:0] : lat[3:0];
    return r;
  endfunction

  function automatic logic [7:0] exp_pc_oe(input logic hi_in, input logic lo_in);
    return {{4{!hi_in}}, {4{!lo_in}}};
  endfunction

  function automatic logic [7:0] bit_word(input int sel, input logic val);
    return {4'b0000, 3'(sel), val};
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; addr = 2'b00; din = 8'h00;
    pa_in = 8'h3C; pb_in = 8'hC5; pc_in = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pb_oe", pb_oe, 8'h00);
    chk("R1 pc_oe", pc_oe, 8'h00);
    chk("R1 pa_out", pa_out, 8'h00);
    rd(2'b11, rv); chk("R1 control read", rv, 8'h00);
    rd(2'b00, rv); chk("R3 R5 port A live read", rv, 8'h3C);
    rd(2'b01, rv); chk("R3 port B live read", rv, 8'hC5);

    // R2 writes without chip select are ignored
    wr(2'b11, 8'h80);
    @(negedge clk); wr_n = 1'b0; addr = 2'b00; din = 8'h77;
    @(negedge clk); wr_n = 1'b1;
    chk("R2 no-cs write", pa_out, 8'h00);
    chk("R2 dout idle", dout, 8'h00);

    // R4 plain output
    wr(2'b00, 8'h77);
    chk("R4 pa_out", pa_out, 8'h77);
    chk("R4 pa_oe", pa_oe, 8'hFF);
    wr(2'b01, 8'h12);
    chk("R4 pb_out", pb_out, 8'h12);
    rd(2'b00, rv); chk("R4 read back A latch", rv, 8'h77);

    // R6 halves and R8 mode clears
    wr(2'b11, 8'h81);
    chk("R8 pa_out cleared", pa_out, 8'h00);
    chk("R8 pb_out cleared", pb_out, 8'h00);
    wr(2'b10, 8'hA5);
    chk("R6 pc_oe halves", pc_oe, 8'hF0);
    pc_in = 8'h3C;
    rd(2'b10, rv); chk("R6 port C mixed read", rv, 8'hAC);
    // R7 single bit set
    wr(2'b11, bit_word(6, 1'b1));
    chk("R7 set bit6", pc_out, 8'hE5);
    wr(2'b11, bit_word(1, 1'b1));
    chk("R7 set bit1", pc_out, 8'hE7);
    wr(2'b11, bit_word(7, 1'b0));
    chk("R7 clear bit7", pc_out, 8'h67);
    wr(2'b11, 8'h80);
    chk("R8 pc latch cleared", pc_out, 8'h00);

    // strobed input on port A
    pc_in = 8'hFF; pa_in = 8'h5A;
    wr(2'b11, 8'hB0);
    chk("R9 pc_oe strobed A in", pc_oe, 8'hEF);
    chk("R9 idle request/full", pc_out & 8'h28, 8'h00);
    wr(2'b11, bit_word(4, 1'b1));
    rd(2'b10, rv); chk("R9 enable at bit4", rv & 8'h10, 8'h10);
    @(negedge clk); pc_in[4] = 1'b0;
    @(negedge clk);
    chk("R10 full after strobe fall", {7'd0, pc_out[5]}, 8'h01);
    chk("R10 no request yet", {7'd0, pc_out[3]}, 8'h00);
    pa_in = 8'h11;
    @(negedge clk); pc_in[4] = 1'b1;
    @(negedge clk);
    chk("R10 request after strobe rise", {7'd0, pc_out[3]}, 8'h01);
    rd(2'b00, rv); chk("R10 captured data", rv, 8'h5A);
    chk("R10 read clears flags", pc_out & 8'h28, 8'h00);
    // second transfer, enable gating
    pa_in = 8'h96;
    @(negedge clk); pc_in[4] = 1'b0;
    @(negedge clk); pc_in[4] = 1'b1;
    @(negedge clk);
    chk("R12 request with enable", {7'd0, pc_out[3]}, 8'h01);
    wr(2'b11, bit_word(4, 1'b0));
    chk("R12 request masked", {7'd0, pc_out[3]}, 8'h00);
    wr(2'b11, bit_word(4, 1'b1));
    chk("R12 request restored", {7'd0, pc_out[3]}, 8'h01);
    wr(2'b11, bit_word(3, 1'b0));
    chk("R13 bit write on request line", {7'd0, pc_out[3]}, 8'h01);
    rd(2'b10, rv); chk("R9 port C status read", rv, 8'h38);
    rd(2'b00, rv); chk("R10 second capture", rv, 8'h96);

    // strobed output on port B
    wr(2'b11, 8'h84);
    chk("R9 full_n idle high", {7'd0, pc_out[1]}, 8'h01);
    chk("R9 ack line input", {7'd0, pc_oe[2]}, 8'h00);
    wr(2'b11, bit_word(2, 1'b1));
    wr(2'b01, 8'hC3);
    chk("R11 pb_out", pb_out, 8'hC3);
    chk("R11 full_n low", {7'd0, pc_out[1]}, 8'h00);
    @(negedge clk); pc_in[2] = 1'b0;
    @(negedge clk);
    chk("R11 ack clears full", {7'd0, pc_out[1]}, 8'h01);
    chk("R11 no request during ack", {7'd0, pc_out[0]}, 8'h00);
    @(negedge clk); pc_in[2] = 1'b1;
    @(negedge clk);
    chk("R11 request after ack", {7'd0, pc_out[0]}, 8'h01);
    wr(2'b01, 8'h3C);
    chk("R11 write clears request", {7'd0, pc_out[0]}, 8'h00);
    chk("R11 write sets full", {7'd0, pc_out[1]}, 8'h00);
    wr(2'b10, 8'h00);
    rd(2'b10, rv); chk("R13 enable kept over C write", rv, 8'h04);
    wr(2'b10, 8'hFF);
    chk("R13 reserved lines unchanged", pc_out, 8'hF8);
    wr(2'b11, 8'h84);
    chk("R8 pb_out cleared", pb_out, 8'h00);
    rd(2'b10, rv); chk("R8 enable and full cleared", rv, 8'h02);

    // constrained random plain mode against the model
    wr(2'b11, 8'h9B);
    la = 8'h00; lb = 8'h00; lc = 8'h00;
    am_in = 1'b1; ch_in = 1'b1; bm_in = 1'b1; cl_in = 1'b1;
    for (int it = 0; it < 400; it++) begin
      logic [7:0] r, d;
      int op;
      op = $urandom_range(0, 6);
      r = 8'($urandom);
      d = 8'($urandom);
      pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
      case (op)
        0: begin
          wr(2'b11, {1'b1, 2'b00, r[4], r[3], 1'b0, r[1], r[0]});
          am_in = r[4]; ch_in = r[3]; bm_in = r[1]; cl_in = r[0];
          la = 8'h00; lb = 8'h00; lc = 8'h00;
        end
        1: begin wr(2'b00, d); if (!am_in) la = d; end
        2: begin wr(2'b01, d); if (!bm_in) lb = d; end
        3: begin wr(2'b10, d); lc = d; end
        4: begin wr(2'b11, bit_word(int'(r[2:0]), r[7])); lc[r[2:0]] = r[7]; end
        5: begin
          case (r[1:0])
            2'b00: begin rd(2'b00, rv); chk("R5 R4 random A read", rv, am_in ? pa_in : la); end
            2'b01: begin rd(2'b01, rv); chk("R5 R4 random B read", rv, bm_in ? pb_in : lb); end
            default: begin
              rd(2'b10, rv);
              chk("R6 random C read", rv, exp_pc_rd(lc, pc_in, ch_in, cl_in));
            end
          endcase
        end
        default: begin rd(2'b11, rv); chk("R3 random control read", rv, 8'h00); end
      endcase
      chk("R4 random pa_out", pa_out, la);
      chk("R4 random pa_oe", pa_oe, am_in ? 8'h00 : 8'hFF);
      chk("R4 random pb_out", pb_out, lb);
      chk("R4 random pb_oe", pb_oe, bm_in ? 8'h00 : 8'hFF);
      chk("R7 random pc_out", pc_out, lc);
      chk("R6 random pc_oe", pc_oe, exp_pc_oe(ch_in, cl_in));
    end

    finish_run();
  end
endmodule